// File: doc/BRIEF.md
# Sector Buffer Fill and Empty Packer

This block moves data between a host data port and a byte-wide sector buffer, one word at a time. A fill operation takes words from the host and packs them into the buffer. An empty operation unpacks the buffer and hands the words back to the host. Each word is asked for with a transfer request. The host answers with an acknowledge, and it may take as long as it likes to do so. The buffer is held in an inferred memory inside the block. A second byte port lets the media side load or inspect the buffer between operations.

Two settings are captured when an operation starts: the word width (8-bit or 12-bit) and the density (single or double). Together they fix how many words move. In 12-bit mode the words are packed back to back into bytes, so a fill leaves bytes unused at the end of the sector, and the block writes zeros into them. Moving the sector to or from the medium is handled by another block.

Top module: `sbuf_packer`

## Requirements
- R1: After reset, xfer_req, done and busy are all 0.
- R2: The number of request/acknowledge handshakes per operation is fixed by the mode. 8-bit mode uses 128 words at single density (dbl_den=0) and 256 at double density. 12-bit mode (wide_mode=1) uses 64 words at single density and 128 at double density.
- R3: In 8-bit mode, fill word k writes host_wdata[7:0] to buffer byte k, and host_wdata[11:8] are ignored. Empty word k presents {4'b0000, byte k} on host_rdata.
- R4: In 12-bit mode, words 2j and 2j+1 occupy bytes 3j to 3j+2, most significant bits first. Byte 3j holds word 2j bits [11:4]. Byte 3j+1 holds word 2j bits [3:0] followed by word 2j+1 bits [11:8]. Byte 3j+2 holds word 2j+1 bits [7:0].
- R5: A 12-bit fill writes zero to every byte from the end of the packed data up to the end of the sector: bytes 96 to 127 at single density, or bytes 192 to 255 at double density.
- R6: An empty reads words back in the same order and packing that fill uses, so filling and then emptying returns the original words.
- R7: There is no timeout. While a word is not acknowledged, xfer_req stays high and, during an empty, host_rdata stays unchanged. No word is lost or skipped however long the stall lasts.
- R8: After the last word, done goes high and xfer_req is low. done stays high until the next start and clears on the cycle after that start is accepted.
- R9: A start pulse that arrives while busy is ignored. The operation in progress keeps its direction, width and word count.
- R10: The media port reads synchronously: med_rdata shows the byte at med_addr one cycle later. Media writes are discarded while busy is high.
- R11: A fill writes only within its sector. In a single-density 8-bit fill, bytes 128 to 255 keep their earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_fill | input | 1 | 1 = fill buffer from host, 0 = empty buffer to host |
| wide_mode | input | 1 | 1 = 12-bit words, 0 = 8-bit words |
| dbl_den | input | 1 | 1 = double density, 0 = single density |
| xfer_req | output | 1 | A word is wanted from, or offered to, the host |
| host_ack | input | 1 | Host accepts or supplies the current word |
| host_wdata | input | 12 | Word from host during fill |
| host_rdata | output | 12 | Word to host during empty |
| done | output | 1 | Last operation has completed |
| busy | output | 1 | An operation is in progress |
| med_addr | input | 8 | Media-side byte address |
| med_we | input | 1 | Media-side byte write enable |
| med_wdata | input | 8 | Media-side write byte |
| med_rdata | output | 8 | Media-side read byte, one cycle after address |

## Verification
The hardest case to reach from the ports is a long stall in the middle of an empty, with a media write landing in the buffer during that stall. The bench holds back the acknowledge for hundreds of cycles partway through a 12-bit empty. It checks on every cycle that the request and the offered word do not change. During the same stall it writes a different value over the byte being offered, then checks that the word finally accepted is still the original one. Start pulses with the opposite direction and width are also injected in the middle of a fill. The bench then confirms from the full buffer contents that the fill finished with its original settings.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_SPILL = 2'd2,
        ST_PAD   = 2'd3
    } sbuf_state_e;

    typedef struct packed {
        logic fill;
        logic wide;
        logic den;
    } sbuf_cfg_t;

endpackage

// File: rtl/sbuf_geom.sv
module sbuf_geom #(
    parameter int BYTES_SD   = 128,
    parameter int WORDS12_SD = 64,
    parameter int CNT_W      = 9
) (
    input  logic             wide,
    input  logic             den,
    output logic [CNT_W-1:0] words,
    output logic [CNT_W-1:0] bytes
);
    localparam logic [CNT_W-1:0] BYTES_BASE = CNT_W'(BYTES_SD);
    localparam logic [CNT_W-1:0] WIDE_BASE  = CNT_W'(WORDS12_SD);

    always_comb begin
        bytes = BYTES_BASE << den;
        words = (wide ? WIDE_BASE : BYTES_BASE) << den;
    end
endmodule

// File: rtl/sbuf_store.sv
module sbuf_store #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [7:0]        a_wdata,
    input  logic [ADDR_W-1:0] r0_addr,
    input  logic [ADDR_W-1:0] r1_addr,
    output logic [7:0]        r0_data,
    output logic [7:0]        r1_data,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [7:0]        b_wdata,
    output logic [7:0]        b_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] b_rdata_q;

    always_ff @(posedge clk) begin
        if (a_we) mem_q[a_addr] <= a_wdata;
        if (b_we) mem_q[b_addr] <= b_wdata;
        b_rdata_q <= mem_q[b_addr];
    end

    always_comb begin
        r0_data = mem_q[r0_addr];
        r1_data = mem_q[r1_addr];
        b_rdata = b_rdata_q;
    end

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_we && b_we)); // R10
endmodule

// File: rtl/sbuf_seq.sv
module sbuf_seq
    import sbuf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_fill,
    input  logic              wide_mode,
    input  logic              dbl_den,
    input  logic              host_ack,
    input  logic [11:0]       host_wdata,
    output logic [11:0]       host_rdata,
    output logic              xfer_req,
    output logic              done,
    output logic              busy,
    input  logic [CNT_W-1:0]  words,
    input  logic [CNT_W-1:0]  bytes,
    output logic              cfg_wide,
    output logic              cfg_den,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [ADDR_W-1:0] rd_addr0,
    output logic [ADDR_W-1:0] rd_addr1,
    input  logic [7:0]        rd_data0,
    input  logic [7:0]        rd_data1
);
    typedef struct packed {
        sbuf_state_e       st;
        logic [ADDR_W-1:0] ptr;
        logic [CNT_W-1:0]  wcnt;
        logic              odd;
        logic [3:0]        nib;
        logic [7:0]        stash;
        sbuf_cfg_t         cfg;
        logic              done;
    } seq_t;

    localparam seq_t SEQ_RESET = '{st: ST_IDLE, ptr: '0, wcnt: '0, odd: 1'b0,
                                   nib: '0, stash: '0, cfg: '0, done: 1'b0};

    seq_t seq_d, seq_q;
    logic last_word;

    always_comb begin
        seq_d     = seq_q;
        wr_en     = 1'b0;
        wr_addr   = seq_q.ptr;
        wr_data   = '0;
        last_word = (seq_q.wcnt == words - CNT_W'(1));

        case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.st   = ST_XFER;
                    seq_d.ptr  = '0;
                    seq_d.wcnt = '0;
                    seq_d.odd  = 1'b0;
                    seq_d.cfg  = '{fill: op_fill, wide: wide_mode, den: dbl_den};
                    seq_d.done = 1'b0;
                end
            end
            ST_XFER: begin
                if (host_ack) begin
                    seq_d.wcnt = seq_q.wcnt + CNT_W'(1);
                    if (seq_q.cfg.fill) begin
                        wr_en = 1'b1;
                        if (!seq_q.cfg.wide) begin
                            wr_data   = host_wdata[7:0];
                            seq_d.ptr = seq_q.ptr + ADDR_W'(1);
                            if (last_word) begin
                                seq_d.st   = ST_IDLE;
                                seq_d.done = 1'b1;
                            end
                        end else if (!seq_q.odd) begin
                            wr_data   = host_wdata[11:4];
                            seq_d.nib = host_wdata[3:0];
                            seq_d.ptr = seq_q.ptr + ADDR_W'(1);
                            seq_d.odd = 1'b1;
                        end else begin
                            wr_data     = {seq_q.nib, host_wdata[11:8]};
                            seq_d.stash = host_wdata[7:0];
                            seq_d.st    = ST_SPILL;
                        end
                    end else begin
                        if (!seq_q.cfg.wide) begin
                            seq_d.ptr = seq_q.ptr + ADDR_W'(1);
                        end else if (!seq_q.odd) begin
                            seq_d.ptr = seq_q.ptr + ADDR_W'(1);
                            seq_d.odd = 1'b1;
                        end else begin
                            seq_d.ptr = seq_q.ptr + ADDR_W'(2);
                            seq_d.odd = 1'b0;
                        end
                        if (last_word) begin
                            seq_d.st   = ST_IDLE;
                            seq_d.done = 1'b1;
                        end
                    end
                end
            end
            ST_SPILL: begin
                wr_en     = 1'b1;
                wr_addr   = seq_q.ptr + ADDR_W'(1);
                wr_data   = seq_q.stash;
                seq_d.ptr = seq_q.ptr + ADDR_W'(2);
                seq_d.odd = 1'b0;
                seq_d.st  = (seq_q.wcnt == words) ? ST_PAD : ST_XFER;
            end
            ST_PAD: begin
                wr_en     = 1'b1;
                wr_data   = 8'h00;
                seq_d.ptr = seq_q.ptr + ADDR_W'(1);
                if ({1'b0, seq_q.ptr} == bytes - CNT_W'(1)) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end
            end
            default: seq_d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= SEQ_RESET;
        else        seq_q <= seq_d;
    end

    always_comb begin
        xfer_req = (seq_q.st == ST_XFER);
        busy     = (seq_q.st != ST_IDLE);
        done     = seq_q.done;
        cfg_wide = seq_q.cfg.wide;
        cfg_den  = seq_q.cfg.den;
        rd_addr0 = seq_q.ptr;
        rd_addr1 = seq_q.ptr + ADDR_W'(1);
        host_rdata = '0;
        if (xfer_req && !seq_q.cfg.fill) begin
            if (!seq_q.cfg.wide)  host_rdata = {4'h0, rd_data0};
            else if (!seq_q.odd)  host_rdata = {rd_data0, rd_data1[7:4]};
            else                  host_rdata = {rd_data0[3:0], rd_data1};
        end
    end

    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !xfer_req); // R8
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !host_ack) |=> xfer_req); // R7
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !host_ack && !seq_q.cfg.fill) |=> $stable(host_rdata)); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(seq_q.cfg)); // R9
    AST_WCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (seq_q.wcnt <= words)); // R2
    AST_PAD_WIDE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_PAD) |-> (seq_q.cfg.wide && seq_q.cfg.fill)); // R5
endmodule

// File: rtl/sbuf_packer.sv
module sbuf_packer #(
    parameter int BYTES_SD   = 128,
    parameter int WORDS12_SD = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        op_fill,
    input  logic        wide_mode,
    input  logic        dbl_den,
    output logic        xfer_req,
    input  logic        host_ack,
    input  logic [11:0] host_wdata,
    output logic [11:0] host_rdata,
    output logic        done,
    output logic        busy,
    input  logic [7:0]  med_addr,
    input  logic        med_we,
    input  logic [7:0]  med_wdata,
    output logic [7:0]  med_rdata
);
    localparam int BUF_BYTES = 2 * BYTES_SD;
    localparam int ADDR_W    = $clog2(BUF_BYTES);
    localparam int CNT_W     = ADDR_W + 1;

    logic [CNT_W-1:0]  words, bytes;
    logic              cfg_wide, cfg_den;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr0, rd_addr1;
    logic [7:0]        wr_data, rd_data0, rd_data1;
    logic              med_we_ok;

    assign med_we_ok = med_we && !busy;

    sbuf_geom #(.BYTES_SD(BYTES_SD), .WORDS12_SD(WORDS12_SD), .CNT_W(CNT_W)) u_geom (
        .wide  (cfg_wide),
        .den   (cfg_den),
        .words (words),
        .bytes (bytes)
    );

    sbuf_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op_fill    (op_fill),
        .wide_mode  (wide_mode),
        .dbl_den    (dbl_den),
        .host_ack   (host_ack),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .xfer_req   (xfer_req),
        .done       (done),
        .busy       (busy),
        .words      (words),
        .bytes      (bytes),
        .cfg_wide   (cfg_wide),
        .cfg_den    (cfg_den),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr0   (rd_addr0),
        .rd_addr1   (rd_addr1),
        .rd_data0   (rd_data0),
        .rd_data1   (rd_data1)
    );

    sbuf_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_we    (wr_en),
        .a_addr  (wr_addr),
        .a_wdata (wr_data),
        .r0_addr (rd_addr0),
        .r1_addr (rd_addr1),
        .r0_data (rd_data0),
        .r1_data (rd_data1),
        .b_we    (med_we_ok),
        .b_addr  (med_addr[ADDR_W-1:0]),
        .b_wdata (med_wdata),
        .b_rdata (med_rdata)
    );
endmodule

// File: tb/sbuf_packer_bench.sv
module sbuf_packer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, op_fill = 1'b0, wide_mode = 1'b0, dbl_den = 1'b0;
    logic        host_ack = 1'b0;
    logic [11:0] host_wdata = '0;
    logic [7:0]  med_addr = '0, med_wdata = '0;
    logic        med_we = 1'b0;
    logic        xfer_req, done, busy;
    logic [11:0] host_rdata;
    logic [7:0]  med_rdata;

    int checks = 0;
    int fails  = 0;
    logic [7:0] mdl [0:255];

    always #4 clk = ~clk;

    sbuf_packer u_sbuf_packer (
        .clk(clk), .rst_n(rst_n), .start(start), .op_fill(op_fill),
        .wide_mode(wide_mode), .dbl_den(dbl_den), .xfer_req(xfer_req),
        .host_ack(host_ack), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .done(done), .busy(busy), .med_addr(med_addr), .med_we(med_we),
        .med_wdata(med_wdata), .med_rdata(med_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] pat(input int k, input int seed);
        return 12'((k * 37 + seed * 91 + 5) ^ (k << 7));
    endfunction

    function automatic logic [11:0] exp_word(input bit wide, input int k);
        int b;
        if (!wide) return {4'h0, mdl[k]};
        b = (k / 2) * 3;
        if (k % 2 == 0) return {mdl[b], mdl[b+1][7:4]};
        return {mdl[b+1][3:0], mdl[b+2]};
    endfunction

    task automatic begin_op(input bit fill, input bit wide, input bit den);
        op_fill = fill; wide_mode = wide; dbl_den = den; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_req();
        while (!xfer_req) @(negedge clk);
    endtask

    task automatic finish_op(input string req, input int n);
        while (!done && !xfer_req) @(negedge clk);
        chk(done && !xfer_req, req, $sformatf("done after %0d words", n), {done, xfer_req}, 2);
    endtask

    task automatic media_write(input int a, input logic [7:0] v);
        med_addr = 8'(a); med_wdata = v; med_we = 1'b1;
        @(negedge clk);
        med_we = 1'b0;
    endtask

    task automatic verify_buf(input string req);
        for (int a = 0; a < 256; a++) begin
            med_addr = 8'(a);
            @(negedge clk);
            chk(med_rdata == mdl[a], req, $sformatf("byte %0d", a), med_rdata, mdl[a]);
        end
    endtask

    task automatic do_fill(input bit wide, input bit den, input int seed, input bit poke);
        int n = wide ? (64 << den) : (128 << den);
        int bytes_n = 128 << den;
        logic [11:0] w;
        begin_op(1'b1, wide, den);
        for (int k = 0; k < n; k++) begin
            wait_req();
            if (poke && (k == 3 || k == 40)) begin
                // R9: start with different settings while busy
                op_fill = 1'b0; wide_mode = ~wide; dbl_den = ~den; start = 1'b1;
                @(negedge clk);
                start = 1'b0; op_fill = 1'b1; wide_mode = wide; dbl_den = den;
            end
            repeat (k % 5) @(negedge clk);
            w = pat(k, seed);
            host_wdata = w; host_ack = 1'b1;
            @(negedge clk);
            host_ack = 1'b0;
            if (!wide) mdl[k] = w[7:0];
            else if (k % 2 == 0) begin
                mdl[(k/2)*3] = w[11:4];
                mdl[(k/2)*3+1][7:4] = w[3:0];
            end else begin
                mdl[(k/2)*3+1][3:0] = w[11:8];
                mdl[(k/2)*3+2] = w[7:0];
            end
        end
        if (wide) for (int a = (n * 3) / 2; a < bytes_n; a++) mdl[a] = 8'h00;
        finish_op("R2", n);
    endtask

    task automatic do_empty(input bit wide, input bit den, input bit stall);
        int n = wide ? (64 << den) : (128 << den);
        logic [11:0] held;
        begin_op(1'b0, wide, den);
        for (int k = 0; k < n; k++) begin
            wait_req();
            if (stall && k == 5) begin
                held = host_rdata;
                for (int c = 0; c < 300; c++) begin
                    if (c == 10) begin
                        med_addr = 8'(((k/2)*3) + 1); med_wdata = ~mdl[((k/2)*3) + 1];
                        med_we = 1'b1;
                    end else med_we = 1'b0;
                    @(negedge clk);
                    chk(xfer_req && host_rdata == held, "R7", "stall hold",
                        host_rdata, held);
                end
                med_we = 1'b0;
                chk(host_rdata == exp_word(wide, k), "R10", "write ignored while busy",
                    host_rdata, exp_word(wide, k));
            end
            repeat (k % 3) @(negedge clk);
            chk(host_rdata == exp_word(wide, k), wide ? "R6" : "R3",
                $sformatf("empty word %0d", k), host_rdata, exp_word(wide, k));
            host_ack = 1'b1;
            @(negedge clk);
            host_ack = 1'b0;
        end
        finish_op("R8", n);
    endtask

    initial begin
        repeat (200000 - 1000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!xfer_req && !done && !busy, "R1", "reset outputs", {xfer_req, done, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!xfer_req && !done && !busy, "R1", "after release", {xfer_req, done, busy}, 0);

        for (int a = 0; a < 256; a++) begin
            mdl[a] = 8'(a * 29 + 8'hA5);
            media_write(a, mdl[a]);
        end
        verify_buf("R10");

        // R3 and R11: single-density byte fill leaves upper half untouched
        do_fill(1'b0, 1'b0, 1, 1'b0);
        verify_buf("R11");
        do_empty(1'b0, 1'b0, 1'b0);

        do_fill(1'b0, 1'b1, 2, 1'b0);
        verify_buf("R3");
        do_empty(1'b0, 1'b1, 1'b0);

        // R4 and R5: packed 12-bit layout with zero pad
        do_fill(1'b1, 1'b0, 3, 1'b1);
        verify_buf("R4");
        do_empty(1'b1, 1'b0, 1'b1);

        do_fill(1'b1, 1'b1, 4, 1'b0);
        verify_buf("R5");
        do_empty(1'b1, 1'b1, 1'b0);

        // R8: done holds while idle, clears after a new start
        repeat (5) begin
            @(negedge clk);
            chk(done && !xfer_req, "R8", "done held", done, 1);
        end
        begin_op(1'b0, 1'b0, 1'b0);
        chk(!done && xfer_req, "R8", "done cleared by start", {done, xfer_req}, 1);
        for (int k = 0; k < 128; k++) begin
            wait_req();
            host_ack = 1'b1;
            @(negedge clk);
            host_ack = 1'b0;
        end
        finish_op("R2", 128);

        // R9: poked fill in byte mode double density
        do_fill(1'b0, 1'b1, 7, 1'b1);
        verify_buf("R9");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule